// File: doc/BRIEF.md
# Four-Rail Undervoltage/Overvoltage Output Controller

This block is the digital back end of a supervisor that watches four supply rails. Each rail reaches it through two comparator flags that are already synchronized to the block clock. One flag comes from the upper divider tap and is true when that tap sits below threshold. The other comes from the lower tap and is true when that tap sits above threshold. A two-bit polarity code decides whether rails 3 and 4 are read as positive or negative supplies. On a negative rail the meaning of the two flags is exchanged. All rail faults merge into one shared active-low undervoltage output and one shared active-low overvoltage output.

Each output stays asserted for a programmable number of clock cycles after its last fault clears. A bypass input removes that hold. The variant parameter picks what the single control input does. In the latching variant it clears a sticky overvoltage latch, and while it is held high it lets the overvoltage output behave like the timed undervoltage output. In the override variant it forces both outputs inactive. A supply-lockout input takes precedence over both: it asserts undervoltage and suppresses overvoltage.

Top module: `rail_supervisor_ctrl`

## Requirements
- R1: While rst_ni is low, uv_n_o is 0 (asserted) and ov_n_o is 1 (deasserted). After reset is released with no fault present, uv_n_o stays low for tmr_limit_i cycles and then rises.
- R2: Rails 1 and 2 (bit 0 and bit 1) are always positive. A set hi_below_i bit is an undervoltage fault and a set lo_above_i bit is an overvoltage fault.
- R3: pol_sel_i selects the polarity of rails 3 and 4 (bits 2 and 3). Code 2'b10 or 2'b11 makes both rails positive. Code 2'b01 makes rail 3 positive and rail 4 negative. Code 2'b00 makes both rails negative. On a negative rail, hi_below_i signals overvoltage and lo_above_i signals undervoltage.
- R4: A fault sampled on a clock edge asserts the matching output after that edge. Once every fault has been sampled clear, the output stays asserted for tmr_limit_i further edges and releases on the next one.
- R5: Any undervoltage fault sampled while a hold is running restarts the hold, and the count starts again from zero once all rails are valid.
- R6: The overvoltage output uses the same hold after clear as the undervoltage output whenever it is not latched.
- R7: With tmr_bypass_i high, an output releases one cycle after its faults are sampled clear.
- R8: In the latching variant, while mode_ctl_i is low an asserted overvoltage output stays asserted after its faults and hold have ended. Driving mode_ctl_i high clears the latch.
- R9: In the latching variant, if mode_ctl_i falls while an overvoltage hold is still running, the overvoltage output latches.
- R10: In the override variant, mode_ctl_i high drives both outputs high one cycle later, whatever the rail flags show.
- R11: lockout_i high asserts uv_n_o and deasserts ov_n_o one cycle later. This also holds in override mode, and it clears the overvoltage latch.
- R12: When lockout_i clears, the undervoltage output follows the normal hold. In override mode it releases one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hi_below_i | input | 4 | Per-rail flag: upper tap below threshold |
| lo_above_i | input | 4 | Per-rail flag: lower tap above threshold |
| pol_sel_i | input | 2 | Polarity code for rails 3 and 4 |
| tmr_limit_i | input | TMR_W | Hold length in cycles after faults clear |
| tmr_bypass_i | input | 1 | Removes the hold |
| mode_ctl_i | input | 1 | Latch clear/bypass (latching variant) or override (override variant) |
| lockout_i | input | 1 | Supply lockout |
| uv_n_o | output | 1 | Shared undervoltage output, active low |
| ov_n_o | output | 1 | Shared overvoltage output, active low |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is lockout together with override: both act on the outputs through the same registered stage. The bench raises lockout while override is high, with rail faults present, and expects UV low and OV high. It then drops lockout and expects UV to release on the following cycle. The second pair is the latch control falling while an overvoltage hold is still counting. The bench lowers it two cycles into a hold and expects OV to stay low past the end of the hold until the control is raised again. Every cycle of every sequence is judged against a behavioural model that runs for both variants.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  localparam int RAILS = 4;

  typedef enum logic [1:0] {
    SEL_NEG_BOTH = 2'b00,
    SEL_SPLIT    = 2'b01,
    SEL_POS_BOTH = 2'b10,
    SEL_POS_ALT  = 2'b11
  } pol_sel_e;
endpackage

// File: rtl/rsup_rail_map.sv
module rsup_rail_map
  import rsup_pkg::*;
(
  input  logic [RAILS-1:0] hi_below_i,
  input  logic [RAILS-1:0] lo_above_i,
  input  logic [1:0]       pol_sel_i,
  output logic             uv_any_o,
  output logic             ov_any_o
);
  logic [RAILS-1:0] neg;
  logic [RAILS-1:0] uv_vec, ov_vec;

  always_comb begin
    neg = '0;
    case (pol_sel_e'(pol_sel_i))
      SEL_NEG_BOTH: begin neg[2] = 1'b1; neg[3] = 1'b1; end
      SEL_SPLIT:    neg[3] = 1'b1;
      default:      neg = '0;
    endcase
  end

  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    // negative rails swap the role of the two taps
    assign uv_vec[r] = neg[r] ? lo_above_i[r] : hi_below_i[r];
    assign ov_vec[r] = neg[r] ? hi_below_i[r] : lo_above_i[r];
  end

  assign uv_any_o = |uv_vec;
  assign ov_any_o = |ov_vec;
endmodule

// File: rtl/rsup_hold_timer.sv
module rsup_hold_timer #(
  parameter int CNT_W    = 16,
  parameter bit RST_BUSY = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic             kill_i,
  input  logic             bypass_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             busy_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= RST_BUSY;
      cnt_q  <= '0;
    end else if (kill_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (fault_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (bypass_i || cnt_q >= limit_i) busy_q <= 1'b0;
      else                              cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/rsup_ov_stage.sv
module rsup_ov_stage #(
  parameter bit OV_LATCH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_ctl_i,
  input  logic lockout_i,
  input  logic ov_busy_i,
  output logic latched_o,
  output logic dis_o
);
  if (OV_LATCH) begin : g_latch
    logic latch_q;
    // control low captures an active OV; control high or lockout clears
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) latch_q <= 1'b0;
      else         latch_q <= !mode_ctl_i && !lockout_i && (latch_q || ov_busy_i);
    end
    assign latched_o = latch_q;
    assign dis_o     = 1'b0;
  end else begin : g_dis
    logic dis_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dis_q <= 1'b0;
      else         dis_q <= mode_ctl_i;
    end
    assign latched_o = 1'b0;
    assign dis_o     = dis_q;
  end
endmodule

// File: rtl/rail_supervisor_ctrl.sv
module rail_supervisor_ctrl
  import rsup_pkg::*;
#(
  parameter bit OV_LATCH = 1'b1,
  parameter int TMR_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RAILS-1:0] hi_below_i,
  input  logic [RAILS-1:0] lo_above_i,
  input  logic [1:0]       pol_sel_i,
  input  logic [TMR_W-1:0] tmr_limit_i,
  input  logic             tmr_bypass_i,
  input  logic             mode_ctl_i,
  input  logic             lockout_i,
  output logic             uv_n_o,
  output logic             ov_n_o
);
  logic uv_any, ov_any;
  logic uv_busy, ov_busy;
  logic ov_latched, dis_q;
  logic lock_q;

  rsup_rail_map u_map (
    .hi_below_i (hi_below_i),
    .lo_above_i (lo_above_i),
    .pol_sel_i  (pol_sel_i),
    .uv_any_o   (uv_any),
    .ov_any_o   (ov_any)
  );

  rsup_hold_timer #(.CNT_W(TMR_W), .RST_BUSY(1'b1)) u_uv_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fault_i  (uv_any || lockout_i),
    .kill_i   (1'b0),
    .bypass_i (tmr_bypass_i),
    .limit_i  (tmr_limit_i),
    .busy_o   (uv_busy)
  );

  rsup_hold_timer #(.CNT_W(TMR_W), .RST_BUSY(1'b0)) u_ov_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fault_i  (ov_any),
    .kill_i   (lockout_i),
    .bypass_i (tmr_bypass_i),
    .limit_i  (tmr_limit_i),
    .busy_o   (ov_busy)
  );

  rsup_ov_stage #(.OV_LATCH(OV_LATCH)) u_ov_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_ctl_i (mode_ctl_i),
    .lockout_i  (lockout_i),
    .ov_busy_i  (ov_busy),
    .latched_o  (ov_latched),
    .dis_o      (dis_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= lockout_i;
  end

  // override masks rail faults but lets lockout through without hold
  assign uv_n_o = !(dis_q ? lock_q : uv_busy);
  assign ov_n_o = !(!lock_q && !dis_q && (ov_busy || ov_latched));
endmodule

// File: rtl/rsup_chk.sv
module rsup_chk
  import rsup_pkg::*;
#(
  parameter bit OV_LATCH = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [RAILS-1:0] hi_below_i,
  input logic [RAILS-1:0] lo_above_i,
  input logic             tmr_bypass_i,
  input logic             mode_ctl_i,
  input logic             lockout_i,
  input logic             uv_n_o,
  input logic             ov_n_o
);
  localparam bit IS_DIS = !OV_LATCH;

  a_r11_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |=> (!uv_n_o && ov_n_o));

  a_r12_release_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uv_n_o) |-> $past(!lockout_i));

  a_r2_pos_rail_uv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|hi_below_i[1:0]) && !(IS_DIS && mode_ctl_i)) |=> !uv_n_o);

  a_r7_bypass_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_bypass_i && hi_below_i == '0 && lo_above_i == '0 && !lockout_i) |=> uv_n_o);

  if (OV_LATCH) begin : g_latch_chk
    a_r8_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ov_n_o && !mode_ctl_i && !lockout_i) |=> !ov_n_o);
  end else begin : g_dis_chk
    a_r10_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_ctl_i && !lockout_i) |=> (uv_n_o && ov_n_o));
  end
endmodule

bind rail_supervisor_ctrl rsup_chk #(.OV_LATCH(OV_LATCH)) u_chk (.*);

// File: tb/rail_supervisor_ctrl_tb_top.sv
module rail_supervisor_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [3:0]    hi = '0, lo = '0;
  logic [1:0]    sel = 2'b10;
  logic [TW-1:0] limit = 16'd4;
  logic          bypass = 1'b0, lockout = 1'b0;
  logic          ctl_latch = 1'b1, ctl_dis = 1'b0;
  logic          uv_n_l, ov_n_l, uv_n_d, ov_n_d;

  int    errors = 0, checks = 0, cycles = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  int uv_on[2], uv_left[2], ov_on[2], ov_left[2], lat[2], lk[2], ds[2];

  always #(CLK_PERIOD/2) clk = !clk;

  rail_supervisor_ctrl #(.OV_LATCH(1'b1), .TMR_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hi_below_i(hi), .lo_above_i(lo),
    .pol_sel_i(sel), .tmr_limit_i(limit), .tmr_bypass_i(bypass),
    .mode_ctl_i(ctl_latch), .lockout_i(lockout), .uv_n_o(uv_n_l), .ov_n_o(ov_n_l));

  rail_supervisor_ctrl #(.OV_LATCH(1'b0), .TMR_W(TW)) dut_dis_i (
    .clk_i(clk), .rst_ni(rst_ni), .hi_below_i(hi), .lo_above_i(lo),
    .pol_sel_i(sel), .tmr_limit_i(limit), .tmr_bypass_i(bypass),
    .mode_ctl_i(ctl_dis), .lockout_i(lockout), .uv_n_o(uv_n_d), .ov_n_o(ov_n_d));

  // rail r is negative per the polarity code of R3
  function automatic bit rail_neg(int r, logic [1:0] s);
    if (r == 2) return s == 2'b00;
    if (r == 3) return s == 2'b00 || s == 2'b01;
    return 1'b0;
  endfunction

  function automatic bit any_uv();
    for (int r = 0; r < 4; r++)
      if (rail_neg(r, sel) ? lo[r] : hi[r]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit any_ov();
    for (int r = 0; r < 4; r++)
      if (rail_neg(r, sel) ? hi[r] : lo[r]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int v = 0; v < 2; v++) begin
        uv_on[v] = 1; uv_left[v] = int'(limit);
        ov_on[v] = 0; ov_left[v] = 0; lat[v] = 0; lk[v] = 0; ds[v] = 0;
      end
    end else begin
      for (int v = 0; v < 2; v++) begin
        automatic bit ctl = (v == 0) ? ctl_latch : ctl_dis;
        automatic int new_lat = (v == 0 && !ctl && !lockout && (lat[v] != 0 || ov_on[v] != 0)) ? 1 : 0;
        if (any_uv() || lockout) begin uv_on[v] = 1; uv_left[v] = int'(limit); end
        else if (uv_on[v] != 0) begin
          if (bypass || uv_left[v] == 0) uv_on[v] = 0; else uv_left[v]--;
        end
        if (lockout) ov_on[v] = 0;
        else if (any_ov()) begin ov_on[v] = 1; ov_left[v] = int'(limit); end
        else if (ov_on[v] != 0) begin
          if (bypass || ov_left[v] == 0) ov_on[v] = 0; else ov_left[v]--;
        end
        lat[v] = new_lat;
        lk[v]  = lockout ? 1 : 0;
        ds[v]  = (v == 1 && ctl) ? 1 : 0;
      end
    end
  end

  task automatic check_one(string who, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%b exp=%b at cycle %0d", cur_req, who, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      check_one("dut_i uv_n", uv_n_l, !(ds[0] != 0 ? lk[0] != 0 : uv_on[0] != 0));
      check_one("dut_i ov_n", ov_n_l, !(lk[0] == 0 && ds[0] == 0 && (ov_on[0] != 0 || lat[0] != 0)));
      check_one("dut_dis_i uv_n", uv_n_d, !(ds[1] != 0 ? lk[1] != 0 : uv_on[1] != 0));
      check_one("dut_dis_i ov_n", ov_n_d, !(lk[1] == 0 && ds[1] == 0 && (ov_on[1] != 0 || lat[1] != 0)));
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    cur_req = "R1"; step(3);
    rst_ni = 1'b1;
    cur_req = "R4"; step(8);
    cur_req = "R2"; hi[0] = 1; step(2); hi = '0; step(7);
    lo[1] = 1; step(2);
    cur_req = "R6"; lo = '0; step(7);
    cur_req = "R3"; sel = 2'b10;
    hi[2] = 1; step(2); hi = '0; step(6);
    lo[3] = 1; step(1); lo = '0; step(6);
    sel = 2'b01;
    hi[3] = 1; step(1); hi = '0; step(6);
    lo[3] = 1; step(1); lo = '0; step(6);
    hi[2] = 1; step(1); hi = '0; step(6);
    sel = 2'b00;
    hi[2] = 1; step(1); hi = '0; step(6);
    lo[2] = 1; step(1); lo = '0; step(6);
    sel = 2'b11;
    hi[3] = 1; step(1); hi = '0; step(6);
    sel = 2'b10;
    cur_req = "R5"; hi[1] = 1; step(2); hi = '0; step(2);
    hi[1] = 1; step(1); hi = '0; step(8);
    cur_req = "R7"; bypass = 1;
    hi[0] = 1; step(2); hi = '0; step(3);
    lo[0] = 1; step(2); lo = '0; step(3);
    bypass = 0;
    cur_req = "R8"; ctl_latch = 0;
    lo[0] = 1; step(2); lo = '0; step(10);
    ctl_latch = 1; step(6);
    cur_req = "R9"; lo[1] = 1; step(1); lo = '0; step(2);
    ctl_latch = 0; step(8); ctl_latch = 1; step(6);
    cur_req = "R10"; ctl_dis = 1;
    hi[0] = 1; lo[1] = 1; step(3); hi = '0; lo = '0; step(3);
    ctl_dis = 0; step(6);
    cur_req = "R11"; ctl_dis = 1; lockout = 1; hi[0] = 1; lo[1] = 1; step(3);
    cur_req = "R12"; lockout = 0; hi = '0; lo = '0; step(3);
    ctl_dis = 0; step(6);
    cur_req = "R11"; ctl_latch = 0; lockout = 1; lo[0] = 1; step(3);
    cur_req = "R12"; lockout = 0; step(1); lo = '0; step(8);
    ctl_latch = 1; step(6);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule